// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter with Split Parking

This block decides which of several bus masters may drive the address phase of a shared, pipelined system bus. Every master has one request line and one lock line. The arbiter also watches the transfer type, the burst type, the slave response and the ready signal on the bus. From these it produces a one-hot grant vector and two owner indices. The address-phase owner selects the master whose address and control reach the slaves. The data-phase owner selects the master whose write data reaches the slaves, and it trails the address-phase owner by one completed transfer.

Priority is fixed: the lowest index wins. When no eligible master requests, the grant parks on master 0. The grant holds while the granted master keeps its lock bit high, and also through a fixed-length burst of 4, 8 or 16 beats. A SPLIT response parks the master that owns the data phase. That master gets no grant until its bit in the split-resume vector is seen. A SPLIT or RETRY response forces a fresh arbitration at the next edge, whatever the lock or burst state.

Top module: `bus_arbiter`

## Requirements
- R1: While rst_ni is low, grant_o is one-hot on master 0, and addr_owner_o and data_owner_o are 0.
- R2: At each edge where arbitration is allowed, the grant moves to the lowest-indexed master among the requesting, non-parked masters. If there is no such master, the grant goes to master 0. grant_o always has exactly one bit set.
- R3: addr_owner_o takes the index of the master granted before an edge only at an edge where ready_i is 1. At any other edge it keeps its value.
- R4: At every edge where ready_i is 1, data_owner_o takes the value that addr_owner_o held just before that edge.
- R5: While the currently granted master holds its lock_i bit at 1, and the response is neither SPLIT nor RETRY, the grant does not change.
- R6: A fixed-length burst holds the grant from its first address beat until its last beat is accepted. The first beat has trans_i = 2'b10 (NONSEQ), and burst_i is one of 3'b010/3'b011 (4 beats), 3'b100/3'b101 (8 beats) or 3'b110/3'b111 (16 beats). The burst continues with trans_i = 2'b11 (SEQ). Only SEQ beats with ready_i = 1 count. BUSY (2'b01) beats and wait states do not count. Re-arbitration happens at the edge after the last beat is accepted.
- R7: Bursts of type SINGLE (3'b000) or undefined-length INCR (3'b001) never hold the grant.
- R8: A SPLIT response (resp_i = 2'b11) parks the master named by data_owner_o. At that same edge the grant is re-arbitrated without that master, overriding any lock or burst hold.
- R9: A set bit in split_resume_i makes that parked master eligible at the same edge. If a resume and a SPLIT hit the same master at the same edge, the SPLIT wins and the master stays parked.
- R10: A RETRY response (resp_i = 2'b10) forces re-arbitration at that edge, overriding any lock or burst hold, and parks no master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Bus request, one bit per master |
| lock_i | input | N_MST | Locked-sequence request, one bit per master |
| trans_i | input | 2 | Transfer type on the bus: IDLE, BUSY, NONSEQ, SEQ |
| burst_i | input | 3 | Burst type on the bus |
| resp_i | input | 2 | Slave response: OKAY, ERROR, RETRY, SPLIT |
| ready_i | input | 1 | Transfer completion on the bus |
| split_resume_i | input | N_MST | Per-master release of a parked master |
| grant_o | output | N_MST | One-hot grant |
| addr_owner_o | output | IW | Index of the address-phase owner |
| data_owner_o | output | IW | Index of the data-phase owner |

## Verification
Two functions can fall on the same edge: a SPLIT response that parks the data-phase owner, and a resume bit for that same master. The bench provokes this by driving SPLIT with the matching split_resume_i bit during the first, non-ready response cycle. It then removes both, keeps the parked master requesting, and checks that the grant stays with the next requester. A lost park would send the grant back to the lower index. A second case forces a lock hold and an abort to meet: a locked master receives RETRY, and the bench checks that the grant moves anyway.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {TR_IDLE = 2'b00, TR_BUSY = 2'b01, TR_NONSEQ = 2'b10, TR_SEQ = 2'b11} trans_e;
  typedef enum logic [1:0] {RS_OKAY = 2'b00, RS_ERROR = 2'b01, RS_RETRY = 2'b10, RS_SPLIT = 2'b11} resp_e;

  localparam int BEAT_W = 5;

  // burst length from the burst code; SINGLE and INCR report one beat (no hold)
  function automatic logic [BEAT_W-1:0] burst_len(input logic [2:0] code);
    case (code[2:1])
      2'b01:   return BEAT_W'(4);
      2'b10:   return BEAT_W'(8);
      2'b11:   return BEAT_W'(16);
      default: return BEAT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_MST = 4,
  parameter int IW    = 2
) (
  input  logic [N_MST-1:0] elig_i,
  output logic [IW-1:0]    idx_o,
  output logic             any_o
);
  // descending scan: lowest set index is written last and wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N_MST - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_split_track.sv
module arb_split_track #(
  parameter int N_MST = 4,
  parameter int IW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] resume_i,
  input  logic             park_i,
  input  logic [IW-1:0]    victim_i,
  output logic [N_MST-1:0] parked_o,
  output logic [N_MST-1:0] block_o
);
  logic [N_MST-1:0] mask_q, victim_oh;

  assign victim_oh = park_i ? (N_MST'(1) << victim_i) : '0;
  // resume opens a slot this edge; a new park on the same master wins
  assign block_o   = (mask_q & ~resume_i) | victim_oh;
  assign parked_o  = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= block_o;
  end
endmodule

// File: rtl/arb_burst_track.sv
module arb_burst_track
  import arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ready_i,
  input  logic [1:0] trans_i,
  input  logic [2:0] burst_i,
  input  logic       abort_i,
  output logic       hold_o
);
  logic [BEAT_W-1:0] left_q, len;
  trans_e            tr;

  assign tr     = trans_e'(trans_i);
  assign len    = burst_len(burst_i);
  assign hold_o = (left_q != '0) || (tr == TR_NONSEQ && len > BEAT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (abort_i) begin
      left_q <= '0;
    end else if (ready_i) begin
      if (tr == TR_NONSEQ)                  left_q <= len - BEAT_W'(1);
      else if (tr == TR_SEQ && left_q != '0) left_q <= left_q - BEAT_W'(1);
    end
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_MST = 4,
  localparam int IW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic [N_MST-1:0] lock_i,
  input  logic [1:0]       trans_i,
  input  logic [2:0]       burst_i,
  input  logic [1:0]       resp_i,
  input  logic             ready_i,
  input  logic [N_MST-1:0] split_resume_i,
  output logic [N_MST-1:0] grant_o,
  output logic [IW-1:0]    addr_owner_o,
  output logic [IW-1:0]    data_owner_o
);
  logic [IW-1:0]    grant_idx_q, addr_idx_q, data_idx_q, pick_idx;
  logic [N_MST-1:0] block, parked, elig;
  logic             pick_any, park_now, abort, burst_hold, lock_hold;
  resp_e            rs;

  assign rs       = resp_e'(resp_i);
  assign park_now = (rs == RS_SPLIT);
  assign abort    = (rs == RS_SPLIT) || (rs == RS_RETRY);

  arb_split_track #(.N_MST(N_MST), .IW(IW)) u_split (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .resume_i (split_resume_i),
    .park_i   (park_now),
    .victim_i (data_idx_q),
    .parked_o (parked),
    .block_o  (block)
  );

  arb_burst_track u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready_i),
    .trans_i (trans_i),
    .burst_i (burst_i),
    .abort_i (abort),
    .hold_o  (burst_hold)
  );

  assign elig = req_i & ~block;

  arb_pick #(.N_MST(N_MST), .IW(IW)) u_pick (
    .elig_i (elig),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  assign lock_hold = lock_i[grant_idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_idx_q <= '0;
    end else if (abort || !(lock_hold || burst_hold)) begin
      grant_idx_q <= pick_any ? pick_idx : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_idx_q <= '0;
      data_idx_q <= '0;
    end else if (ready_i) begin
      addr_idx_q <= grant_idx_q;
      data_idx_q <= addr_idx_q;
    end
  end

  assign grant_o      = N_MST'(1) << grant_idx_q;
  assign addr_owner_o = addr_idx_q;
  assign data_owner_o = data_idx_q;

  logic unused_parked;
  assign unused_parked = ^parked;
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int N_MST = 4,
  parameter int IW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] lock_i,
  input logic [1:0]       resp_i,
  input logic             ready_i,
  input logic [N_MST-1:0] grant_o,
  input logic [IW-1:0]    addr_owner_o,
  input logic [IW-1:0]    data_owner_o
);
  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(addr_owner_o));

  // R4
  data_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> data_owner_o == $past(addr_owner_o));

  // R5
  lock_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(grant_o & lock_i)) && !resp_i[1]) |=> $stable(grant_o));

  // R8
  split_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_i == 2'b11 && data_owner_o != '0) |=> !grant_o[$past(data_owner_o)]);

  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == 1);
endmodule

bind bus_arbiter arb_chk #(.N_MST(N_MST), .IW(IW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lock_i       (lock_i),
  .resp_i       (resp_i),
  .ready_i      (ready_i),
  .grant_o      (grant_o),
  .addr_owner_o (addr_owner_o),
  .data_owner_o (data_owner_o)
);

// File: tb/sim_bus_arbiter.sv
`timescale 1ns/1ps
module sim_bus_arbiter;
  localparam int N = 4;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0, lock = '0, resume = '0;
  logic [1:0]   trans = 2'b00, resp = 2'b00;
  logic [2:0]   burst = 3'b000;
  logic         ready = 1'b1;
  logic [N-1:0] grant;
  logic [W-1:0] a_own, d_own;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_arbiter #(.N_MST(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .lock_i(lock), .trans_i(trans),
    .burst_i(burst), .resp_i(resp), .ready_i(ready), .split_resume_i(resume),
    .grant_o(grant), .addr_owner_o(a_own), .data_owner_o(d_own)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_bit(input int v);
    for (int i = 0; i < N; i++) if (v[i]) return 1 << i;
    return 1;
  endfunction

  function automatic int oh2idx(input int v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int g_prev, a_prev;
    tick();
    chk("R1 grant", grant, 1);
    chk("R1 addr", a_own, 0);
    chk("R1 data", d_own, 0);
    #3 rst_n = 1'b1;
    tick();

    // R2/R3/R4 sweep over all request patterns
    for (int r = 0; r < (1 << N); r++) begin
      for (int k = 0; k < 2; k++) begin
        req = N'(r);
        g_prev = grant;
        a_prev = a_own;
        tick();
        chk("R2 prio", grant, (r == 0) ? 1 : low_bit(r));
        chk("R3 addr", a_own, oh2idx(g_prev));
        chk("R4 data", d_own, a_prev);
      end
    end

    // R3 ready low freezes owners
    req = 4'b0010; tick(); tick(); tick();
    ready = 1'b0; req = 4'b1000;
    tick();
    chk("R3 grant moves", grant, 8);
    chk("R3 addr frozen", a_own, 1);
    tick();
    chk("R3 addr frozen2", a_own, 1);
    chk("R4 data frozen", d_own, 1);
    ready = 1'b1;
    tick();
    chk("R3 addr updates", a_own, 3);
    chk("R4 data updates", d_own, 1);

    // R5 lock
    req = 4'b0100; tick();
    chk("R5 setup", grant, 4);
    lock = 4'b0100; req = 4'b0101;
    tick(); chk("R5 held", grant, 4);
    tick(); chk("R5 held2", grant, 4);
    lock = '0;
    tick(); chk("R5 released", grant, 1);

    // R6 INCR4 burst with BUSY and wait state
    req = 4'b0010; tick(); tick();
    req = 4'b0011; trans = 2'b10; burst = 3'b011;
    tick(); chk("R6 nonseq", grant, 2);
    trans = 2'b11; tick(); chk("R6 seq1", grant, 2);
    trans = 2'b01; tick(); chk("R6 busy", grant, 2);
    trans = 2'b11; ready = 1'b0; tick(); chk("R6 wait", grant, 2);
    ready = 1'b1; tick(); chk("R6 seq2", grant, 2);
    tick(); chk("R6 seq3 last", grant, 2);
    trans = 2'b00; tick(); chk("R6 rearb", grant, 1);

    // R7 undefined-length INCR does not hold
    req = 4'b0010; tick(); tick();
    req = 4'b0011; trans = 2'b10; burst = 3'b001;
    tick(); chk("R7 incr free", grant, 1);
    trans = 2'b00; burst = 3'b000;

    // R8 SPLIT parks data owner, overrides lock
    req = 4'b0010; tick(); tick(); tick();
    chk("R8 setup data", d_own, 1);
    req = 4'b0110; lock = 4'b0010; resp = 2'b11; ready = 1'b0;
    tick(); chk("R8 split rearb", grant, 4);
    ready = 1'b1; tick(); chk("R8 split 2nd", grant, 4);
    resp = 2'b00; lock = '0;
    tick(); chk("R8 parked", grant, 4);
    tick(); chk("R8 parked2", grant, 4);
    req = 4'b0010;
    tick(); chk("R8 park on 0", grant, 1);

    // R9 resume
    resume = 4'b0010;
    tick(); chk("R9 resume", grant, 2);
    resume = '0;
    tick(); chk("R9 cleared", grant, 2);

    // R9 split and resume on same master, same edge
    tick(); tick(); tick();
    chk("R9 setup data", d_own, 1);
    req = 4'b0110; resp = 2'b11; ready = 1'b0; resume = 4'b0010;
    tick(); chk("R9 both rearb", grant, 4);
    resp = 2'b00; ready = 1'b1; resume = '0;
    tick(); chk("R9 split wins", grant, 4);
    resume = 4'b0010;
    tick(); chk("R9 later resume", grant, 2);
    resume = '0;

    // R10 RETRY overrides lock, parks nobody
    req = 4'b0100; tick(); tick();
    lock = 4'b0100; req = 4'b0101;
    tick(); chk("R10 lock setup", grant, 4);
    resp = 2'b10; ready = 1'b0;
    tick(); chk("R10 retry rearb", grant, 1);
    resp = 2'b00; ready = 1'b1; req = 4'b0100;
    tick(); chk("R10 no park", grant, 4);
    lock = '0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule